// File: doc/BRIEF.md
# SPI Buffer Status Tracker

This block sits between a memory-mapped host register port and an SPI shift engine. It holds one transmit word and one receive word and tracks whether each slot is occupied. It flags overruns on both sides, and each side has its own policy. A late received word replaces the unread one. A host write into an occupied transmit slot is thrown away. A further flag is raised whenever a word that crosses the host port matches a programmed marker value.

The host sees a status word and can read it freely. Any write to the status address clears the error and marker flags. A control register selects which status bits drive the single level-sensitive interrupt line. The shift engine is modelled by a small handshake:
- a take pulse that consumes the transmit word,
- a busy level,
- a receive-valid pulse carrying the incoming word.

Host address map:
- 0: receive data (read)
- 1: transmit data (write)
- 2: status
- 3: interrupt enable (write)
- 4: marker value (write)

Reads of other addresses return zero.

Top module: `spi_buf_status`

## Requirements
- R1: After reset the status word reads 0x0060 while the engine is idle, and irq is low. The status bit positions are: bit 3 receive overrun, bit 4 transmit overrun, bit 5 shifter empty, bit 6 transmit ready, bit 7 receive ready, bit 8 any-error, bit 9 marker match. All other bits read 0.
- R2: A host write to address 1 while transmit ready is 1 stores the word. The stored word is presented on eng_tx_data and eng_tx_valid rises. Transmit ready drops to 0. An eng_tx_take pulse sets transmit ready back to 1.
- R3: A host write to address 1 while transmit ready is 0 sets transmit overrun. The written word is discarded, so eng_tx_data keeps the earlier word.
- R4: An eng_rx_valid pulse stores eng_rx_data and sets receive ready. A host read of address 0 returns the stored word and clears receive ready.
- R5: An eng_rx_valid pulse while receive ready is 1, with no receive read in the same cycle, sets receive overrun. The new word replaces the old one.
- R6: If a word arrives in the same cycle as a host read of address 0, the read returns the old word. The new word is kept, receive ready stays 1 and no receive overrun is raised.
- R7: Any write to address 2 clears the receive overrun, transmit overrun, any-error and marker bits, whatever the write data is. A flag raised in that same cycle is set, not cleared.
- R8: Reading the status word changes no bit.
- R9: The any-error bit always equals receive overrun OR transmit overrun.
- R10: The shifter-empty bit is 1 exactly when eng_busy is 0.
- R11: The marker bit is set, and stays set, when a host transmit write carries the marker value, or when a host receive read returns the marker value.
- R12: irq is high exactly when some status bit and its enable bit (same position in the address 3 register) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | DW | Host write data |
| reg_rdata | output | DW | Host read data, combinational |
| irq | output | 1 | Level interrupt |
| eng_tx_valid | output | 1 | Transmit slot occupied |
| eng_tx_data | output | DW | Transmit word to the shifter |
| eng_tx_take | input | 1 | Shifter consumes the transmit word |
| eng_busy | input | 1 | Shifter transfer in progress |
| eng_rx_valid | input | 1 | Received word strobe |
| eng_rx_data | input | DW | Received word |

## Verification
Two functions can land in the same cycle:
- a host read of the receive slot and a new arrival from the shifter;
- a clearing write to the status word and a fresh receive overrun.

The bench drives each pair on a single clock. In the first case it expects the read to return the old word, then a status word with receive ready set and no overrun, then the new word on the next read. In the second case it expects the overrun and any-error bits to survive the clear.

// File: rtl/spi_bs_pkg.sv
package spi_bs_pkg;
  localparam int ROE_B  = 3;
  localparam int TOE_B  = 4;
  localparam int TMT_B  = 5;
  localparam int TRDY_B = 6;
  localparam int RRDY_B = 7;
  localparam int ERR_B  = 8;
  localparam int EOP_B  = 9;
  localparam int STW    = EOP_B + 1;

  typedef enum logic [2:0] {
    A_RXDATA = 3'd0,
    A_TXDATA = 3'd1,
    A_STATUS = 3'd2,
    A_IRQEN  = 3'd3,
    A_MARK   = 3'd4
  } addr_e;
endpackage

// File: rtl/spi_bs_txreg.sv
module spi_bs_txreg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data,
  output logic          ovr
);
  logic          full_n;
  logic          ld;

  always_comb begin
    ld     = wr & ~full;
    ovr    = wr & full;
    full_n = full;
    if (ld)        full_n = 1'b1;
    else if (take) full_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_n;
      if (ld) data <= wdata;
    end
  end
endmodule

// File: rtl/spi_bs_rxreg.sv
module spi_bs_rxreg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arrive,
  input  logic [DW-1:0] din,
  input  logic          rd,
  output logic          full,
  output logic [DW-1:0] data,
  output logic          ovr
);
  logic full_n;

  always_comb begin
    ovr    = arrive & full & ~rd;
    full_n = arrive | (full & ~rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_n;
      if (arrive) data <= din;
    end
  end
endmodule

// File: rtl/spi_bs_flags.sv
module spi_bs_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic roe_set,
  input  logic toe_set,
  input  logic eop_set,
  input  logic clr,
  output logic roe,
  output logic toe,
  output logic eop
);
  logic roe_n, toe_n, eop_n;

  always_comb begin
    roe_n = roe_set | (roe & ~clr);
    toe_n = toe_set | (toe & ~clr);
    eop_n = eop_set | (eop & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      roe <= 1'b0;
      toe <= 1'b0;
      eop <= 1'b0;
    end else begin
      roe <= roe_n;
      toe <= toe_n;
      eop <= eop_n;
    end
  end
endmodule

// File: rtl/spi_buf_status.sv
module spi_buf_status
  import spi_bs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          eng_tx_valid,
  output logic [DW-1:0] eng_tx_data,
  input  logic          eng_tx_take,
  input  logic          eng_busy,
  input  logic          eng_rx_valid,
  input  logic [DW-1:0] eng_rx_data
);
  addr_e          addr;
  logic           wr_tx, wr_st, wr_en, wr_mk, rd_rx;
  logic [STW-1:0] en_q, en_n;
  logic [DW-1:0]  mark_q, mark_n;
  logic           rx_full, rx_ovr, tx_ovr;
  logic [DW-1:0]  rx_data;
  logic           roe, toe, eop, eop_hit;
  logic [STW-1:0] status_w;

  always_comb begin
    addr  = addr_e'(reg_addr);
    wr_tx = reg_wr && (addr == A_TXDATA);
    wr_st = reg_wr && (addr == A_STATUS);
    wr_en = reg_wr && (addr == A_IRQEN);
    wr_mk = reg_wr && (addr == A_MARK);
    rd_rx = reg_rd && (addr == A_RXDATA);
  end

  always_comb begin
    en_n   = wr_en ? reg_wdata[STW-1:0] : en_q;
    mark_n = wr_mk ? reg_wdata : mark_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mark_q <= '0;
    end else begin
      en_q   <= en_n;
      mark_q <= mark_n;
    end
  end

  spi_bs_txreg #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .wr(wr_tx), .wdata(reg_wdata),
    .take(eng_tx_take), .full(eng_tx_valid), .data(eng_tx_data), .ovr(tx_ovr)
  );

  spi_bs_rxreg #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .arrive(eng_rx_valid), .din(eng_rx_data),
    .rd(rd_rx), .full(rx_full), .data(rx_data), .ovr(rx_ovr)
  );

  assign eop_hit = (wr_tx && (reg_wdata == mark_q)) || (rd_rx && (rx_data == mark_q));

  spi_bs_flags u_flags (
    .clk(clk), .rst_n(rst_n), .roe_set(rx_ovr), .toe_set(tx_ovr),
    .eop_set(eop_hit), .clr(wr_st), .roe(roe), .toe(toe), .eop(eop)
  );

  always_comb begin
    status_w         = '0;
    status_w[ROE_B]  = roe;
    status_w[TOE_B]  = toe;
    status_w[TMT_B]  = ~eng_busy;
    status_w[TRDY_B] = ~eng_tx_valid;
    status_w[RRDY_B] = rx_full;
    status_w[ERR_B]  = roe | toe;
    status_w[EOP_B]  = eop;
  end

  assign irq = |(status_w & en_q);

  always_comb begin
    reg_rdata = '0;
    case (addr)
      A_RXDATA: reg_rdata = rx_data;
      A_STATUS: reg_rdata[STW-1:0] = status_w;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_buf_status_chk.sv
module spi_buf_status_chk
  import spi_bs_pkg::*;
#(
  parameter int DW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic           reg_rd,
  input logic [2:0]     reg_addr,
  input logic           eng_rx_valid,
  input logic           eng_tx_take,
  input logic [DW-1:0]  eng_tx_data,
  input logic [STW-1:0] status_w
);
  localparam logic [STW-1:0] STABLE_M = ~(STW'(1) << TMT_B);
  localparam logic [STW-1:0] CLR_M =
    (STW'(1) << ROE_B) | (STW'(1) << TOE_B) | (STW'(1) << ERR_B) | (STW'(1) << EOP_B);

  AST_TRDY_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tx_take && !(reg_wr && reg_addr == A_TXDATA) |=> status_w[TRDY_B]); // R2
  AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_TXDATA && !status_w[TRDY_B] |=> eng_tx_data == $past(eng_tx_data)); // R3
  AST_RX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == A_RXDATA && !eng_rx_valid |=> !status_w[RRDY_B]); // R4
  AST_ROE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_valid && status_w[RRDY_B] && !(reg_rd && reg_addr == A_RXDATA) |=> status_w[ROE_B]); // R5
  AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == A_STATUS && !eng_rx_valid && !reg_rd |=> (status_w & CLR_M) == '0); // R7
  AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == A_STATUS && !reg_wr && !eng_rx_valid && !eng_tx_take
    |=> (status_w & STABLE_M) == $past(status_w & STABLE_M)); // R8
endmodule

bind spi_buf_status spi_buf_status_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .eng_rx_valid(eng_rx_valid), .eng_tx_take(eng_tx_take), .eng_tx_data(eng_tx_data),
  .status_w(status_w)
);

// File: tb/spi_buf_status_tb.sv
module spi_buf_status_tb;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr, reg_rd;
  logic [2:0]    reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic          irq, eng_tx_valid, eng_tx_take, eng_busy, eng_rx_valid;
  logic [DW-1:0] eng_tx_data, eng_rx_data;

  always #5 clk = ~clk;

  spi_buf_status #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_take(eng_tx_take),
    .eng_busy(eng_busy), .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data)
  );

  typedef struct {
    int            sel;
    logic [DW-1:0] exp;
    string         tag;
  } item_t;

  item_t q[$];
  event  smp;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  function automatic logic [DW-1:0] observe(int sel);
    case (sel)
      0:       return reg_rdata;
      1:       return eng_tx_data;
      2:       return {{(DW-1){1'b0}}, irq};
      default: return {{(DW-1){1'b0}}, eng_tx_valid};
    endcase
  endfunction

  // monitor: pops expected items and compares them with the design outputs
  initial forever begin
    item_t it;
    logic [DW-1:0] got;
    @(smp);
    while (q.size() > 0) begin
      it  = q.pop_front();
      got = observe(it.sel);
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s got %h exp %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic expect_now(int sel, logic [DW-1:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
    #2;
    -> smp;
    #0;
  endtask

  task automatic cyc(logic wr, logic rd, logic [2:0] a, logic [DW-1:0] d,
                     logic rxv, logic [DW-1:0] rxd, logic take);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    eng_rx_valid = rxv; eng_rx_data = rxd; eng_tx_take = take;
  endtask

  task automatic idle();
    cyc(0, 0, 3'd0, '0, 0, '0, 0);
  endtask

  task automatic chk_status(logic [DW-1:0] exp, string tag);
    cyc(0, 1, 3'd2, '0, 0, '0, 0);
    expect_now(0, exp, tag);
  endtask

  task automatic wr_reg(logic [2:0] a, logic [DW-1:0] d);
    cyc(1, 0, a, d, 0, '0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    eng_rx_valid = 0; eng_rx_data = '0; eng_tx_take = 0; eng_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk_status(16'h0060, "R1 reset status");
    expect_now(2, 16'h0, "R1 reset irq");

    wr_reg(3'd1, 16'h1234);
    chk_status(16'h0020, "R2 trdy low after write");
    expect_now(1, 16'h1234, "R2 tx word presented");
    expect_now(3, 16'h1, "R2 tx valid");

    wr_reg(3'd1, 16'h5555);
    chk_status(16'h0130, "R3 TOE and R9 E set");
    expect_now(1, 16'h1234, "R3 dropped word");

    wr_reg(3'd2, 16'h0000);
    chk_status(16'h0020, "R7 clear with zero data");

    @(negedge clk);
    eng_busy = 1;
    reg_wr = 0; reg_rd = 0; eng_tx_take = 1;
    chk_status(16'h0040, "R2 take sets trdy, R10 busy clears tmt");
    @(negedge clk);
    eng_busy = 0;
    chk_status(16'h0060, "R10 tmt back when idle");

    cyc(0, 0, 3'd0, '0, 1, 16'hAAAA, 0);
    chk_status(16'h00E0, "R4 rrdy set");
    cyc(0, 0, 3'd0, '0, 1, 16'hBBBB, 0);
    chk_status(16'h01E8, "R5 ROE and R9 E");
    chk_status(16'h01E8, "R8 read leaves status");
    cyc(0, 1, 3'd0, '0, 0, '0, 0);
    expect_now(0, 16'hBBBB, "R5 overwrite kept new");
    chk_status(16'h0168, "R4 read clears rrdy");
    wr_reg(3'd2, 16'hFFFF);
    chk_status(16'h0060, "R7 clear with ones data");

    wr_reg(3'd4, 16'h00C3);
    wr_reg(3'd1, 16'h00C3);
    chk_status(16'h0220, "R11 marker on tx write");
    cyc(0, 0, 3'd0, '0, 0, '0, 1);
    wr_reg(3'd2, 16'h0);
    chk_status(16'h0060, "R11 marker cleared");
    cyc(0, 0, 3'd0, '0, 1, 16'h00C3, 0);
    cyc(0, 1, 3'd0, '0, 0, '0, 0);
    expect_now(0, 16'h00C3, "R4 read word");
    chk_status(16'h0260, "R11 marker on rx read");
    wr_reg(3'd2, 16'h0);

    cyc(0, 0, 3'd0, '0, 1, 16'h0011, 0);
    cyc(0, 1, 3'd0, '0, 1, 16'h0022, 0);
    expect_now(0, 16'h0011, "R6 read returns old word");
    chk_status(16'h00E0, "R6 no overrun, rrdy kept");

    cyc(1, 0, 3'd2, '0, 1, 16'h0033, 0);
    chk_status(16'h01E8, "R7 new overrun wins over clear");

    wr_reg(3'd3, 16'h0008);
    idle();
    expect_now(2, 16'h1, "R12 irq on ROE enable");
    wr_reg(3'd3, 16'h0010);
    idle();
    expect_now(2, 16'h0, "R12 irq low, TOE clear");
    wr_reg(3'd3, 16'h0080);
    idle();
    expect_now(2, 16'h1, "R12 irq on RRDY enable");
    wr_reg(3'd3, 16'h0000);
    idle();
    expect_now(2, 16'h0, "R12 irq masked");

    idle();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule